// File: doc/BRIEF.md
# Z80 I/O Cycle to Wishbone Bridge

This block sits between the I/O side of a Z80-style processor core and a synchronous Wishbone master port. Peripherals attached behind it see ordinary single Wishbone transfers rather than raw CPU I/O strobes. A peripheral can still attach to the plain I/O controller instead; the bridge only claims ports inside its configured window.

The processor core driving it may hold its write strobe for only two clocks. Its data lines fall back on the same edge as that strobe, so nothing can be sampled once the strobe has ended. The bridge therefore takes the port number, write data and direction on the first clock edge where an I/O request and a read or write strobe are seen together. It runs the Wishbone transfer from those stored values.

For reads, the bridge pulls the CPU wait line until the peripheral acknowledges. It then holds the returned byte on the CPU data input for as long as the read strobe stays active.

Top module: `zio_wb_bridge`

## Requirements
- R1: After reset, `wb_cyc_o`, `wb_stb_o` and `wb_we_o` are 0, `cpu_wait_n` is 1 and `cpu_din_oe` is 0.
- R2: On the first rising edge where `cpu_iorq_n`=0 and `cpu_wr_n`=0 for an in-window port, the low address byte and `cpu_dout` are stored. `wb_adr_o` and `wb_dat_o` then keep those values for the whole Wishbone transfer, even when the strobe lasts only two clocks and the CPU data changes when it ends.
- R3: `wb_cyc_o` and `wb_stb_o` rise together on the clock after capture. They stay high while `wb_ack_i` is 0 and fall on the clock after `wb_ack_i` is sampled 1.
- R4: During a transfer, `wb_we_o` is 1 for a CPU write and 0 for a CPU read, and every bit of `wb_sel_o` is 1.
- R5: For an in-window read, `cpu_wait_n` goes to 0 in the same cycle the read strobe is first seen. It stays 0 up to and including the cycle where `wb_ack_i` is sampled, then returns to 1. Writes never drive `cpu_wait_n` to 0.
- R6: The byte on `wb_dat_i` at the acknowledge edge of a read is presented on `cpu_din` with `cpu_din_oe`=1 until the read strobe is removed. `cpu_din_oe` drops in the same cycle the strobe becomes inactive.
- R7: An I/O access to a port whose low address byte lies outside [WIN_LO, WIN_HI] (default 0x40..0x4F) starts no Wishbone transfer, leaves `cpu_wait_n` at 1 and leaves `cpu_din_oe` at 0.
- R8: Only address bits [7:0] are decoded, and `wb_adr_o` carries exactly that byte. The upper address byte never affects the window decision.
- R9: A strobe that begins while a transfer or read hand-back is in progress is ignored. A strobe still active after its own transfer completes starts nothing further until it goes inactive.
- R10: A read or write strobe without `cpu_iorq_n`=0 (a memory cycle) starts no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock shared by the CPU core and Wishbone |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_dout | input | 8 | Data driven by the CPU |
| cpu_iorq_n | input | 1 | I/O request, active low |
| cpu_rd_n | input | 1 | Read strobe, active low |
| cpu_wr_n | input | 1 | Write strobe, active low |
| cpu_din | output | 8 | Read data returned to the CPU |
| cpu_din_oe | output | 1 | High while `cpu_din` should be driven onto the CPU |
| cpu_wait_n | output | 1 | Wait request to the CPU, active low |
| wb_adr_o | output | 8 | Wishbone address (I/O port number) |
| wb_dat_o | output | 8 | Wishbone write data |
| wb_dat_i | input | 8 | Wishbone read data |
| wb_we_o | output | 1 | Wishbone write enable |
| wb_sel_o | output | 1 | Wishbone byte select, all ones |
| wb_stb_o | output | 1 | Wishbone strobe |
| wb_cyc_o | output | 1 | Wishbone cycle |
| wb_ack_i | input | 1 | Wishbone acknowledge |

## Verification
The hardest case to reach from the ports is a fresh strobe edge arriving while a transfer is still open. The bench creates it by holding back the acknowledge: it opens a write and leaves it unacknowledged, then ends the write strobe and issues a read strobe to another in-window port. It then acknowledges and confirms that no second transfer appears. A second variant holds a strobe active well past its acknowledge, so the edge detector has to refuse the level that is still present. The short-write case changes `cpu_dout` on the same edge the strobe is removed, so a late capture would show up as corrupted `wb_dat_o`.

// File: rtl/zio_wb_pkg.sv
package zio_wb_pkg;

  localparam int IO_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUS  = 2'd1,
    ST_HOLD = 2'd2
  } bridge_st_t;

  // True when an I/O port number lies inside the inclusive window [lo, hi].
  function automatic logic in_io_window(input logic [IO_W-1:0] port,
                                        input logic [IO_W-1:0] lo,
                                        input logic [IO_W-1:0] hi);
    return (port >= lo) && (port <= hi);
  endfunction

  // An I/O cycle is under way when the request and either strobe are low.
  function automatic logic io_strobe_live(input logic iorq_n,
                                          input logic rd_n,
                                          input logic wr_n);
    return !iorq_n && (!rd_n || !wr_n);
  endfunction

endpackage

// File: rtl/zio_cycle_detect.sv
module zio_cycle_detect
  import zio_wb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [IO_W-1:0] WIN_LO = 8'h40,
  parameter logic [IO_W-1:0] WIN_HI = 8'h4F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dout,
  input  logic              iorq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              idle,
  output logic              start_evt,
  output logic              start_rd,
  output logic              rd_live,
  output logic [IO_W-1:0]   cap_port,
  output logic [DATA_W-1:0] cap_data,
  output logic              cap_we
);

  logic req_now;
  logic req_q;
  logic win_hit;

  assign req_now   = io_strobe_live(iorq_n, rd_n, wr_n);
  assign win_hit   = in_io_window(addr[IO_W-1:0], WIN_LO, WIN_HI);
  assign start_evt = req_now && !req_q && idle && win_hit;
  assign start_rd  = !rd_n;
  assign rd_live   = !iorq_n && !rd_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else begin
      req_q <= req_now;
    end
  end

  // Capture on the very first edge of the strobe: the data may vanish next.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_port <= '0;
      cap_data <= '0;
      cap_we   <= 1'b0;
    end else if (start_evt) begin
      cap_port <= addr[IO_W-1:0];
      cap_data <= dout;
      cap_we   <= !wr_n;
    end
  end

endmodule

// File: rtl/zio_wb_master.sv
module zio_wb_master
  import zio_wb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_evt,
  input  logic cap_we,
  input  logic rd_live,
  input  logic ack,
  output logic idle,
  output logic bus_active,
  output logic hold_active,
  output logic rd_ack_take
);

  bridge_st_t st_q;
  bridge_st_t st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_evt) st_d = ST_BUS;
      ST_BUS:  if (ack) st_d = cap_we ? ST_IDLE : ST_HOLD;
      ST_HOLD: if (!rd_live) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  assign idle        = (st_q == ST_IDLE);
  assign bus_active  = (st_q == ST_BUS);
  assign hold_active = (st_q == ST_HOLD);
  assign rd_ack_take = bus_active && ack && !cap_we;

endmodule

// File: rtl/zio_read_return.sv
module zio_read_return #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [DATA_W-1:0] wb_data,
  input  logic              hold_active,
  input  logic              rd_live,
  output logic [DATA_W-1:0] din,
  output logic              din_oe
);

  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (take) begin
      rdata_q <= wb_data;
    end
  end

  assign din    = rdata_q;
  assign din_oe = hold_active && rd_live;

endmodule

// File: rtl/zio_wb_bridge.sv
module zio_wb_bridge
  import zio_wb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [IO_W-1:0] WIN_LO = 8'h40,
  parameter logic [IO_W-1:0] WIN_HI = 8'h4F,
  localparam int SEL_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_dout,
  input  logic              cpu_iorq_n,
  input  logic              cpu_rd_n,
  input  logic              cpu_wr_n,
  output logic [DATA_W-1:0] cpu_din,
  output logic              cpu_din_oe,
  output logic              cpu_wait_n,
  output logic [IO_W-1:0]   wb_adr_o,
  output logic [DATA_W-1:0] wb_dat_o,
  input  logic [DATA_W-1:0] wb_dat_i,
  output logic              wb_we_o,
  output logic [SEL_W-1:0]  wb_sel_o,
  output logic              wb_stb_o,
  output logic              wb_cyc_o,
  input  logic              wb_ack_i
);

  // Named internal events, visible to the bound checker.
  logic start_evt;
  logic start_rd;
  logic rd_live;
  logic idle;
  logic bus_active;
  logic hold_active;
  logic rd_ack_take;
  logic cap_we;

  zio_cycle_detect #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .WIN_LO (WIN_LO),
    .WIN_HI (WIN_HI)
  ) detect_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (cpu_addr),
    .dout      (cpu_dout),
    .iorq_n    (cpu_iorq_n),
    .rd_n      (cpu_rd_n),
    .wr_n      (cpu_wr_n),
    .idle      (idle),
    .start_evt (start_evt),
    .start_rd  (start_rd),
    .rd_live   (rd_live),
    .cap_port  (wb_adr_o),
    .cap_data  (wb_dat_o),
    .cap_we    (cap_we)
  );

  zio_wb_master master_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_evt   (start_evt),
    .cap_we      (cap_we),
    .rd_live     (rd_live),
    .ack         (wb_ack_i),
    .idle        (idle),
    .bus_active  (bus_active),
    .hold_active (hold_active),
    .rd_ack_take (rd_ack_take)
  );

  zio_read_return #(
    .DATA_W (DATA_W)
  ) ret_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .take        (rd_ack_take),
    .wb_data     (wb_dat_i),
    .hold_active (hold_active),
    .rd_live     (rd_live),
    .din         (cpu_din),
    .din_oe      (cpu_din_oe)
  );

  assign wb_cyc_o = bus_active;
  assign wb_stb_o = bus_active;
  assign wb_we_o  = bus_active && cap_we;
  assign wb_sel_o = {SEL_W{1'b1}};

  // A read waits from the strobe's first cycle until the acknowledge is taken.
  assign cpu_wait_n = !((start_evt && start_rd) || (bus_active && !cap_we));

endmodule

// File: rtl/zio_wb_bridge_chk.sv
module zio_wb_bridge_chk
  import zio_wb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [IO_W-1:0] WIN_LO = 8'h40,
  parameter logic [IO_W-1:0] WIN_HI = 8'h4F,
  localparam int SEL_W = DATA_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_iorq_n,
  input logic              cpu_rd_n,
  input logic              cpu_wr_n,
  input logic              cpu_din_oe,
  input logic              cpu_wait_n,
  input logic [IO_W-1:0]   wb_adr_o,
  input logic [DATA_W-1:0] wb_dat_o,
  input logic              wb_we_o,
  input logic [SEL_W-1:0]  wb_sel_o,
  input logic              wb_stb_o,
  input logic              wb_cyc_o,
  input logic              wb_ack_i,
  input logic              start_evt
);

  assert_hold_until_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc_o && !wb_ack_i) |=> (wb_cyc_o && wb_stb_o));

  assert_drop_after_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc_o && wb_ack_i) |=> !wb_cyc_o);

  assert_rise_after_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (wb_cyc_o && wb_stb_o));

  assert_capture_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc_o && !wb_ack_i) |=> ($stable(wb_adr_o) && $stable(wb_dat_o) && $stable(wb_we_o)));

  assert_sel_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_cyc_o |-> (wb_sel_o == {SEL_W{1'b1}}));

  assert_read_waits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc_o && !wb_we_o) |-> !cpu_wait_n);

  assert_write_no_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc_o && wb_we_o) |-> cpu_wait_n);

  assert_oe_needs_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_din_oe |-> (!cpu_iorq_n && !cpu_rd_n));

  assert_window_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> in_io_window(cpu_addr[IO_W-1:0], WIN_LO, WIN_HI));

  assert_busy_ignores_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc_o || cpu_din_oe) |-> !start_evt);

  assert_needs_iorq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> !cpu_iorq_n);

endmodule

bind zio_wb_bridge zio_wb_bridge_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .WIN_LO (WIN_LO),
  .WIN_HI (WIN_HI)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_addr   (cpu_addr),
  .cpu_iorq_n (cpu_iorq_n),
  .cpu_rd_n   (cpu_rd_n),
  .cpu_wr_n   (cpu_wr_n),
  .cpu_din_oe (cpu_din_oe),
  .cpu_wait_n (cpu_wait_n),
  .wb_adr_o   (wb_adr_o),
  .wb_dat_o   (wb_dat_o),
  .wb_we_o    (wb_we_o),
  .wb_sel_o   (wb_sel_o),
  .wb_stb_o   (wb_stb_o),
  .wb_cyc_o   (wb_cyc_o),
  .wb_ack_i   (wb_ack_i),
  .start_evt  (start_evt)
);

// File: tb/zio_wb_bridge_tb_top.sv
module zio_wb_bridge_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_dout = '0;
  logic        cpu_iorq_n = 1'b1;
  logic        cpu_rd_n = 1'b1;
  logic        cpu_wr_n = 1'b1;
  logic [7:0]  cpu_din;
  logic        cpu_din_oe;
  logic        cpu_wait_n;
  logic [7:0]  wb_adr_o;
  logic [7:0]  wb_dat_o;
  logic [7:0]  wb_dat_i = '0;
  logic        wb_we_o;
  logic [0:0]  wb_sel_o;
  logic        wb_stb_o;
  logic        wb_cyc_o;
  logic        wb_ack_i = 1'b0;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  zio_wb_bridge dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_addr   (cpu_addr),
    .cpu_dout   (cpu_dout),
    .cpu_iorq_n (cpu_iorq_n),
    .cpu_rd_n   (cpu_rd_n),
    .cpu_wr_n   (cpu_wr_n),
    .cpu_din    (cpu_din),
    .cpu_din_oe (cpu_din_oe),
    .cpu_wait_n (cpu_wait_n),
    .wb_adr_o   (wb_adr_o),
    .wb_dat_o   (wb_dat_o),
    .wb_dat_i   (wb_dat_i),
    .wb_we_o    (wb_we_o),
    .wb_sel_o   (wb_sel_o),
    .wb_stb_o   (wb_stb_o),
    .wb_cyc_o   (wb_cyc_o),
    .wb_ack_i   (wb_ack_i)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Bench-side restatement of the decode: low byte only, inclusive 0x40..0x4F.
  function automatic bit claims(input logic [15:0] a);
    return (a[7:0] >= 8'h40) && (a[7:0] < 8'h50);
  endfunction

  task automatic idle_cpu();
    cpu_iorq_n = 1'b1;
    cpu_rd_n   = 1'b1;
    cpu_wr_n   = 1'b1;
  endtask

  task automatic ack_now(input logic [7:0] data);
    wb_ack_i = 1'b1;
    wb_dat_i = data;
    @(negedge clk);
    wb_ack_i = 1'b0;
    wb_dat_i = 8'h00;
  endtask

  task automatic t_reset();
    chk("R1 cyc", wb_cyc_o, 0);
    chk("R1 stb", wb_stb_o, 0);
    chk("R1 we", wb_we_o, 0);
    chk("R1 wait_n", cpu_wait_n, 1);
    chk("R1 oe", cpu_din_oe, 0);
  endtask

  // Two-clock write strobe; data bus changes on the edge the strobe ends.
  task automatic t_write_short();
    @(negedge clk);
    cpu_addr = 16'h1244; cpu_dout = 8'hA5; cpu_iorq_n = 1'b0; cpu_wr_n = 1'b0;
    #1 chk("R5 write no wait", cpu_wait_n, 1);
    @(negedge clk);
    chk("R3 cyc after capture", wb_cyc_o, 1);
    chk("R3 stb after capture", wb_stb_o, 1);
    chk("R4 we write", wb_we_o, 1);
    chk("R4 sel", wb_sel_o, 1);
    chk("R8 adr low byte", wb_adr_o, 8'h44);
    @(negedge clk);
    idle_cpu(); cpu_dout = 8'h3C; cpu_addr = 16'h0000;
    repeat (3) @(negedge clk);
    chk("R3 held without ack", wb_cyc_o, 1);
    chk("R2 data kept", wb_dat_o, 8'hA5);
    chk("R2 adr kept", wb_adr_o, 8'h44);
    ack_now(8'h00);
    chk("R3 drop after ack", wb_cyc_o, 0);
    chk("R3 stb drop", wb_stb_o, 0);
  endtask

  task automatic t_read(input logic [15:0] a, input logic [7:0] val, input int delay);
    @(negedge clk);
    cpu_addr = a; cpu_iorq_n = 1'b0; cpu_rd_n = 1'b0;
    #1 chk("R5 wait on first cycle", cpu_wait_n, 0);
    @(negedge clk);
    chk("R4 we read", wb_we_o, 0);
    chk("R3 cyc read", wb_cyc_o, 1);
    for (int i = 0; i < delay; i++) begin
      chk("R5 wait held", cpu_wait_n, 0);
      @(negedge clk);
    end
    chk("R5 wait in ack cycle", cpu_wait_n, 0);
    ack_now(val);
    chk("R5 wait released", cpu_wait_n, 1);
    chk("R6 oe", cpu_din_oe, 1);
    chk("R6 data", cpu_din, val);
    chk("R3 cyc dropped", wb_cyc_o, 0);
    // Strobe kept active longer: data stays, nothing restarts (R9).
    repeat (3) @(negedge clk);
    chk("R6 data kept", cpu_din, val);
    chk("R9 no restart while held", wb_cyc_o, 0);
    idle_cpu();
    #1 chk("R6 oe drops with strobe", cpu_din_oe, 0);
    @(negedge clk);
  endtask

  task automatic t_no_claim(input logic [15:0] a, input bit is_rd, input bit use_iorq, input string req);
    @(negedge clk);
    cpu_addr = a; cpu_iorq_n = !use_iorq;
    if (is_rd) cpu_rd_n = 1'b0; else cpu_wr_n = 1'b0;
    #1 chk({req, " wait"}, cpu_wait_n, 1);
    repeat (3) begin
      @(negedge clk);
      chk({req, " no cyc"}, wb_cyc_o, 0);
      chk({req, " no oe"}, cpu_din_oe, 0);
    end
    idle_cpu();
    @(negedge clk);
  endtask

  // New strobe edge while the write is unacknowledged must be dropped.
  task automatic t_busy_ignore();
    @(negedge clk);
    cpu_addr = 16'h0041; cpu_dout = 8'h11; cpu_iorq_n = 1'b0; cpu_wr_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    idle_cpu();
    @(negedge clk);
    cpu_addr = 16'h0049; cpu_iorq_n = 1'b0; cpu_rd_n = 1'b0;
    #1 chk("R9 no wait while busy", cpu_wait_n, 1);
    @(negedge clk);
    chk("R9 adr unchanged", wb_adr_o, 8'h41);
    chk("R9 still write", wb_we_o, 1);
    ack_now(8'h00);
    for (int i = 0; i < 3; i++) begin
      chk("R9 no second cycle", wb_cyc_o, 0);
      @(negedge clk);
    end
    idle_cpu();
    @(negedge clk);
  endtask

  // Long write strobe: one transfer only.
  task automatic t_write_long();
    @(negedge clk);
    cpu_addr = 16'hFF4F; cpu_dout = 8'h7E; cpu_iorq_n = 1'b0; cpu_wr_n = 1'b0;
    @(negedge clk);
    chk("R7 top edge of window", wb_cyc_o, 1);
    chk("R2 long write data", wb_dat_o, 8'h7E);
    ack_now(8'h00);
    repeat (4) begin
      chk("R9 held write no repeat", wb_cyc_o, 0);
      @(negedge clk);
    end
    idle_cpu();
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_write_short();
    t_read(16'h0040, 8'h5A, 0);
    t_read(16'hC34D, 8'hC3, 4);
    t_no_claim(16'h0080, 1'b1, 1'b1, "R7 read outside");
    t_no_claim(16'h003F, 1'b0, 1'b1, "R7 write below");
    t_no_claim(16'h4210, 1'b0, 1'b1, "R8 upper byte in window");
    if (!claims(16'h4210)) chk("R8 bench decode", 0, 0);
    t_no_claim(16'h0044, 1'b0, 1'b0, "R10 write no iorq");
    t_no_claim(16'h0044, 1'b1, 1'b0, "R10 read no iorq");
    t_busy_ignore();
    t_write_long();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule